// File: doc/BRIEF.md
# Message-Buffer Interrupt Flag Bank

This block holds one sticky interrupt flag for each of 32 message buffers, plus a matching mask register, and folds the masked flags into a single interrupt request. A buffer that finishes a transmit or a receive pulses its event strobe for one clock. That pulse sets the buffer's flag. The flag then stays set until software writes a 1 to that bit position in the flag register. A 0 written to any bit leaves it alone.

A receive-FIFO mode input changes how the low eight flags are used. While the mode is on, flags 5, 6 and 7 record three FIFO conditions: frames available, almost full and overflow. Flags 0 to 4 are reserved, and buffer strobes for buffers 0 to 7 are ignored. The block never clears a flag on its own when the mode or the number of active buffers changes. Software must clear stale flags itself.

Register access is a single-cycle port with a one-bit register select. Reads are combinational and have no side effects. The interrupt output is registered.

Top module: `mbirq_bank`

## Requirements
- R1: After reset, the flag register, the mask register and `irq` all read zero.
- R2: With FIFO mode off, a one-cycle pulse on `buf_done[n]` sets flag bit n (n = 0..31). The flag can be read at `reg_sel`=0 from the clock edge that samples the pulse onward.
- R3: A set flag stays set through idle cycles for as long as no 1 is written to its position.
- R4: A write at `reg_sel`=0 clears every flag whose `reg_wdata` bit is 1. Flags whose `reg_wdata` bit is 0 are unchanged.
- R5: If a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R6: The mask register (`reg_sel`=1) is a plain read/write register. A write stores `reg_wdata`, and a read returns the stored value.
- R7: `irq` is 1 exactly one clock after some visible flag bit and the same mask bit are both 1. It is 0 one clock after no such pair exists.
- R8: With FIFO mode on, `fifo_avail` sets bit 5, `fifo_warn` sets bit 6 and `fifo_ovf` sets bit 7, and `buf_done[7:0]` has no effect. With FIFO mode off, the three FIFO strobes have no effect.
- R9: With FIFO mode on, flag bits 4..0 read as zero, ignore writes and do not drive `irq`. Their stored values reappear when FIFO mode is turned off.
- R10: Turning FIFO mode on or off clears no flag.
- R11: Reading either register changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_done | input | 32 | Per-buffer transmit/receive completion strobes |
| fifo_avail | input | 1 | FIFO frames-available strobe |
| fifo_warn | input | 1 | FIFO almost-full strobe |
| fifo_ovf | input | 1 | FIFO overflow strobe |
| fifo_mode | input | 1 | Receive-FIFO mode enable |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 1 | Register select: 0 = flags, 1 = mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Registered interrupt request |

## Verification
The flag path is exercised with the following stimulus patterns:
- Scattered multi-bit strobes on the lowest, a middle and the highest buffer, which expose bit-mapping slips.
- Partial, zero and all-ones clear writes, which separate write-one-to-clear from plain write.
- A strobe and a clear landing on the same bit in one cycle, which confirms that the set has priority.

The interrupt is tested in several ways. A strobe on an unmasked bit must leave `irq` low, and a strobe on a masked bit must raise it. The bench samples `irq` both in the cycle right after the flag appears and in the cycle after that, to confirm the one-cycle lag. It also drops the mask and checks that `irq` falls.

FIFO mode is tested in three ways. Low buffer strobes and FIFO strobes are each sent in the mode where they should be ignored. Reserved bits are written and read while hidden. The mode is toggled with high and low flags pending, which shows that reserved state is kept and that no flag is lost.

// File: rtl/mbirq_pkg.sv
package mbirq_pkg;
  localparam int unsigned NUM_BUF   = 32;
  localparam int unsigned FIFO_SPAN = 8;
  localparam int unsigned BIT_AVAIL = 5;
  localparam int unsigned BIT_WARN  = 6;
  localparam int unsigned BIT_OVF   = 7;
  localparam int unsigned RSVD_CNT  = 5;

  typedef logic [NUM_BUF-1:0] flag_vec_t;

  typedef enum logic {
    SEL_FLAGS = 1'b0,
    SEL_MASK  = 1'b1
  } reg_sel_e;

  // Vector with the lowest n bits set.
  function automatic flag_vec_t low_ones(int unsigned n);
    flag_vec_t v;
    v = '0;
    for (int unsigned i = 0; i < NUM_BUF; i++) begin
      if (i < n) v[i] = 1'b1;
    end
    return v;
  endfunction

  // Flags as software and the interrupt see them: reserved bits hidden in FIFO mode.
  function automatic flag_vec_t visible_flags(flag_vec_t stored, logic fifo_on);
    return fifo_on ? (stored & ~low_ones(RSVD_CNT)) : stored;
  endfunction

  // Next flag state: a set event takes priority over a clear.
  function automatic flag_vec_t next_flags(flag_vec_t cur, flag_vec_t set_v, flag_vec_t clr_v);
    return set_v | (cur & ~clr_v);
  endfunction
endpackage

// File: rtl/mbirq_event_map.sv
module mbirq_event_map
  import mbirq_pkg::*;
(
  input  logic      fifo_mode,
  input  flag_vec_t buf_done,
  input  logic      fifo_avail,
  input  logic      fifo_warn,
  input  logic      fifo_ovf,
  output flag_vec_t set_vec
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_map
    if (i == BIT_AVAIL) begin : g_avail
      assign set_vec[i] = fifo_mode ? fifo_avail : buf_done[i];
    end else if (i == BIT_WARN) begin : g_warn
      assign set_vec[i] = fifo_mode ? fifo_warn : buf_done[i];
    end else if (i == BIT_OVF) begin : g_ovf
      assign set_vec[i] = fifo_mode ? fifo_ovf : buf_done[i];
    end else if (i < FIFO_SPAN) begin : g_rsvd
      assign set_vec[i] = fifo_mode ? 1'b0 : buf_done[i];
    end else begin : g_plain
      assign set_vec[i] = buf_done[i];
    end
  end
endmodule

// File: rtl/mbirq_flag_array.sv
module mbirq_flag_array
  import mbirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fifo_mode,
  input  flag_vec_t set_vec,
  input  logic      clr_we,
  input  flag_vec_t clr_data,
  output flag_vec_t flag_q
);
  flag_vec_t clr_vec;
  flag_vec_t flag_d;

  // Reserved bits cannot be cleared while FIFO mode hides them.
  assign clr_vec = clr_we ? (clr_data & ~(fifo_mode ? low_ones(RSVD_CNT) : '0)) : '0;
  assign flag_d  = next_flags(flag_q, set_vec, clr_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_chk
    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag_q[i]); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr_vec[i]) |=> flag_q[i]); // R3
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]); // R4
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[i] && !set_vec[i]) |=> !flag_q[i]); // R11
  end

  for (genvar r = 0; r < RSVD_CNT; r++) begin : g_rsvd_chk
    AST_RSVD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_mode |=> flag_q[r] == $past(flag_q[r])); // R9
  end
endmodule

// File: rtl/mbirq_irq_gen.sv
module mbirq_irq_gen
  import mbirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mask_we,
  input  flag_vec_t mask_wdata,
  input  flag_vec_t vis_flags,
  output flag_vec_t mask_q,
  output logic      irq
);
  logic pending;

  assign pending = |(vis_flags & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      irq <= pending;
    end
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> irq); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> !irq); // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q)); // R6
endmodule

// File: rtl/mbirq_bank.sv
module mbirq_bank
  import mbirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] buf_done,
  input  logic        fifo_avail,
  input  logic        fifo_warn,
  input  logic        fifo_ovf,
  input  logic        fifo_mode,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  flag_vec_t set_vec;
  flag_vec_t flag_q;
  flag_vec_t vis_flags;
  flag_vec_t mask_q;
  logic      flag_we;
  logic      mask_we;

  assign flag_we = reg_we && (reg_sel_e'(reg_sel) == SEL_FLAGS);
  assign mask_we = reg_we && (reg_sel_e'(reg_sel) == SEL_MASK);

  mbirq_event_map u_map (
    .fifo_mode (fifo_mode),
    .buf_done  (buf_done),
    .fifo_avail(fifo_avail),
    .fifo_warn (fifo_warn),
    .fifo_ovf  (fifo_ovf),
    .set_vec   (set_vec)
  );

  mbirq_flag_array u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_mode(fifo_mode),
    .set_vec  (set_vec),
    .clr_we   (flag_we),
    .clr_data (reg_wdata),
    .flag_q   (flag_q)
  );

  assign vis_flags = visible_flags(flag_q, fifo_mode);

  mbirq_irq_gen u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (mask_we),
    .mask_wdata(reg_wdata),
    .vis_flags (vis_flags),
    .mask_q    (mask_q),
    .irq       (irq)
  );

  always_comb begin
    if (reg_sel_e'(reg_sel) == SEL_MASK) reg_rdata = mask_q;
    else                                 reg_rdata = vis_flags;
  end

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && reg_sel == 1'b0) |-> reg_rdata[RSVD_CNT-1:0] == '0); // R9
  AST_LOW_BUF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && !flag_q[0] && !flag_we) |=> !flag_q[0]); // R8
endmodule

// File: tb/mbirq_bank_bench.sv
module mbirq_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] buf_done = '0;
  logic        fifo_avail = 1'b0, fifo_warn = 1'b0, fifo_ovf = 1'b0;
  logic        fifo_mode = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  mbirq_bank u_mbirq_bank (
    .clk(clk), .rst_n(rst_n), .buf_done(buf_done), .fifo_avail(fifo_avail),
    .fifo_warn(fifo_warn), .fifo_ovf(fifo_ovf), .fifo_mode(fifo_mode),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [31:0] b);
    buf_done = b; step(); buf_done = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(1'b0, v); check("R1 flags", v, 32'h0);
    rd(1'b1, v); check("R1 mask", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_set_sticky();
    logic [31:0] v;
    pulse(32'h8000_0101);
    rd(1'b0, v); check("R2 set", v, 32'h8000_0101);
    repeat (3) step();
    rd(1'b0, v); check("R3 sticky", v, 32'h8000_0101);
    rd(1'b1, v); rd(1'b0, v); rd(1'b0, v);
    check("R11 read twice", v, 32'h8000_0101);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(1'b0, 32'h0000_0100);
    rd(1'b0, v); check("R4 partial", v, 32'h8000_0001);
    wr(1'b0, 32'h0);
    rd(1'b0, v); check("R4 zero write", v, 32'h8000_0001);
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); check("R4 all clear", v, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    pulse(32'h0000_0008);
    buf_done = 32'h0000_0008;
    wr(1'b0, 32'h0000_0008);
    buf_done = '0;
    rd(1'b0, v); check("R5 set wins", v, 32'h0000_0008);
    wr(1'b0, 32'h0000_0008);
    rd(1'b0, v); check("R4 clear after", v, 32'h0);
  endtask

  task automatic t_mask_irq();
    logic [31:0] v;
    wr(1'b1, 32'h0000_0010);
    rd(1'b1, v); check("R6 mask rb", v, 32'h0000_0010);
    pulse(32'h0000_0200);
    step();
    check("R7 unmasked no irq", {31'h0, irq}, 32'h0);
    pulse(32'h0000_0010);
    check("R7 lag", {31'h0, irq}, 32'h0);
    step();
    check("R7 irq rise", {31'h0, irq}, 32'h1);
    wr(1'b1, 32'h0);
    check("R7 fall lag", {31'h0, irq}, 32'h1);
    step();
    check("R7 irq fall", {31'h0, irq}, 32'h0);
    wr(1'b0, 32'hFFFF_FFFF);
  endtask

  task automatic t_fifo();
    logic [31:0] v;
    fifo_ovf = 1'b1; step(); fifo_ovf = 1'b0;
    rd(1'b0, v); check("R8 fifo strobe ignored", v, 32'h0);
    fifo_mode = 1'b1; step();
    pulse(32'h0000_00FF);
    rd(1'b0, v); check("R8 low bufs ignored", v, 32'h0);
    fifo_avail = 1'b1; step(); fifo_avail = 1'b0;
    rd(1'b0, v); check("R8 avail bit5", v, 32'h0000_0020);
    fifo_warn = 1'b1; step(); fifo_warn = 1'b0;
    fifo_ovf = 1'b1; step(); fifo_ovf = 1'b0;
    rd(1'b0, v); check("R8 warn/ovf bits", v, 32'h0000_00E0);
    wr(1'b0, 32'hFFFF_FFFF);
    fifo_mode = 1'b0; step();
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    pulse(32'h0010_0005);
    fifo_mode = 1'b1; step();
    rd(1'b0, v); check("R9 rsvd read zero", v, 32'h0010_0000);
    check("R10 high kept on", v, 32'h0010_0000);
    wr(1'b0, 32'h0000_001F);
    wr(1'b1, 32'h0000_001F);
    step();
    check("R9 rsvd no irq", {31'h0, irq}, 32'h0);
    fifo_mode = 1'b0; step();
    rd(1'b0, v); check("R9 rsvd restored", v, 32'h0010_0005);
    check("R10 mode off keeps", v, 32'h0010_0005);
    check("R9 irq after restore", {31'h0, irq}, 32'h1);
    wr(1'b1, 32'h0);
    wr(1'b0, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_sticky();
    t_w1c();
    t_set_wins();
    t_mask_irq();
    t_fifo();
    t_reserved();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule